// File: doc/BRIEF.md
# Debug Comparator Hit Qualifier

This block sits behind one breakpoint or watchpoint address comparator and decides whether a raw address hit becomes a real debug event. It filters the hit by the security state of the access, by the privilege level the access runs at, and, when the comparator is linked, by a context-ID compare done with a second comparator chosen from a bank of slots.

The control word of the qualified comparator holds a two-bit security selector, a two-bit privilege mask, a higher-level enable, a link-enable bit and a four-bit link number. The link number drives a mux over the bank's value and control registers. The selected slot's type field picks which context-ID register is compared with the low half of its value register. The qualified result is registered and appears one clock after the inputs.

Top module: `dbq_qualifier`

## Requirements
- R1: `match_q` is low during and after synchronous reset, is low one cycle after any cycle with `hit_in` low, and otherwise follows the qualification of the previous cycle's inputs.
- R2: Security selector (`ctl_word[4:3]`): 0 passes both states; 1 and 3 block secure accesses (`secure`=1); 2 blocks non-secure accesses.
- R3: At effective level 2 or 3 the hit passes only when the higher-level enable `ctl_word[2]` is 1.
- R4: At effective level 1 the hit needs privilege mask bit `ctl_word[0]`; at effective level 0 it needs `ctl_word[1]`.
- R5: When `is_wp` and `user_attr` are both 1, the effective level is 0 whatever `cur_lvl` holds; for breakpoints `user_attr` has no effect.
- R6: With link enable `ctl_word[5]`=1, the link number `ctl_word[9:6]` must lie in NUM_BP-NUM_CTX .. NUM_BP-1 (12..15 by default), else the hit is rejected.
- R7: The linked slot's control bit 0 must be 1, else the hit is rejected.
- R8: Linked type 3 (slot control bits 23:20) compares against the current regime's ID: level 1 uses `ctx_l1`; level 2 uses `ctx_l2` only when `host_ext` is 1 and fails otherwise; level 0 uses `ctx_l2` when `host_ext` and `gen_trap` are both 1, else `ctx_l1`; level 3 fails. This uses `cur_lvl`, not the effective level.
- R9: Linked type 7 compares `ctx_l1`, type 13 compares `ctx_l2`; every other type rejects the hit.
- R10: Only the low 32 bits of the linked slot's 64-bit value take part in the compare.
- R11: With link enable 0 the link number and the slot bank have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_in | input | 1 | Raw address hit from the comparator |
| is_wp | input | 1 | 1 for a watchpoint, 0 for a breakpoint |
| user_attr | input | 1 | Access carried the unprivileged attribute |
| ctl_word | input | 10 | Qualified comparator control word |
| cur_lvl | input | 2 | Current privilege level 0..3 |
| secure | input | 1 | Access is in the secure state |
| host_ext | input | 1 | Hypervisor host-extension bit |
| gen_trap | input | 1 | Hypervisor general-trap bit |
| ctx_l1 | input | 32 | Level-1 context ID |
| ctx_l2 | input | 32 | Level-2 context ID |
| lnk_val_flat | input | NUM_BP*64 | Value registers of all slots, slot 0 lowest |
| lnk_ctl_flat | input | NUM_BP*32 | Control registers of all slots, slot 0 lowest |
| match_q | output | 1 | Registered qualified match |

## Verification
The bound assertions watch every cycle for the rejecting rules that depend only on ports: a missing hit, a blocked security state, a missing higher-level enable, a link number outside the context slots and a disabled linked slot must each leave the output low the next cycle. Whether a hit is accepted, and which context-ID register the linked type and level select, is shown only by the bench: directed cases for each type and level combination, the slot-range edges and the upper value bits, plus random traffic compared with a reference model.

// File: rtl/dbq_pkg.sv
package dbq_pkg;

    localparam int LNUM_W   = 4;
    localparam int CWORD_W  = 10;
    localparam int SLOT_EN  = 0;
    localparam int TYPE_LSB = 20;
    localparam int TYPE_W   = 4;

    typedef struct packed {
        logic [LNUM_W-1:0] lnk_num;
        logic              lnk_en;
        logic [1:0]        sec_sel;
        logic              hi_mode;
        logic [1:0]        priv_mask;
    } ctl_word_t;

    typedef enum logic [1:0] {
        LVL_0 = 2'd0,
        LVL_1 = 2'd1,
        LVL_2 = 2'd2,
        LVL_3 = 2'd3
    } lvl_e;

    typedef enum logic [1:0] {
        SEC_ANY     = 2'd0,
        SEC_NS_A    = 2'd1,
        SEC_S_ONLY  = 2'd2,
        SEC_NS_B    = 2'd3
    } sec_sel_e;

    localparam logic [TYPE_W-1:0] LT_REGIME = 4'd3;
    localparam logic [TYPE_W-1:0] LT_CTX_L1 = 4'd7;
    localparam logic [TYPE_W-1:0] LT_CTX_L2 = 4'd13;

    function automatic logic sec_pass(input sec_sel_e sel, input logic is_sec);
        case (sel)
            SEC_ANY:    return 1'b1;
            SEC_S_ONLY: return is_sec;
            default:    return !is_sec;
        endcase
    endfunction

    function automatic logic priv_pass(input lvl_e lvl, input logic hi_mode,
                                       input logic [1:0] mask);
        case (lvl)
            LVL_0:   return mask[1];
            LVL_1:   return mask[0];
            default: return hi_mode;
        endcase
    endfunction

endpackage

// File: rtl/dbq_sec_filter.sv
module dbq_sec_filter
    import dbq_pkg::*;
(
    input  logic [1:0] sec_sel,
    input  logic       secure,
    output logic       sec_ok
);
    always_comb begin
        sec_ok = sec_pass(sec_sel_e'(sec_sel), secure);
    end
endmodule

// File: rtl/dbq_priv_filter.sv
module dbq_priv_filter
    import dbq_pkg::*;
(
    input  logic [1:0] cur_lvl,
    input  logic       is_wp,
    input  logic       user_attr,
    input  logic       hi_mode,
    input  logic [1:0] priv_mask,
    output logic       priv_ok
);
    lvl_e eff_lvl;

    always_comb begin
        if (is_wp && user_attr) eff_lvl = LVL_0;
        else                    eff_lvl = lvl_e'(cur_lvl);
        priv_ok = priv_pass(eff_lvl, hi_mode, priv_mask);
    end
endmodule

// File: rtl/dbq_link_match.sv
module dbq_link_match
    import dbq_pkg::*;
#(
    parameter int NUM_BP  = 16,
    parameter int NUM_CTX = 4,
    parameter int VAL_W   = 64,
    parameter int CTX_W   = 32,
    parameter int CTL_W   = 32
) (
    input  logic [LNUM_W-1:0]       lnk_num,
    input  logic [1:0]              cur_lvl,
    input  logic                    host_ext,
    input  logic                    gen_trap,
    input  logic [CTX_W-1:0]        ctx_l1,
    input  logic [CTX_W-1:0]        ctx_l2,
    input  logic [NUM_BP*VAL_W-1:0] lnk_val_flat,
    input  logic [NUM_BP*CTL_W-1:0] lnk_ctl_flat,
    output logic                    link_ok
);
    localparam int FIRST_CTX = NUM_BP - NUM_CTX;
    localparam int IDX_W     = (NUM_BP > 1) ? $clog2(NUM_BP) : 1;

    logic [VAL_W-1:0] val_arr [NUM_BP];
    logic [CTL_W-1:0] ctl_arr [NUM_BP];

    generate
        for (genvar g = 0; g < NUM_BP; g++) begin : g_unpack
            assign val_arr[g] = lnk_val_flat[g*VAL_W +: VAL_W];
            assign ctl_arr[g] = lnk_ctl_flat[g*CTL_W +: CTL_W];
        end
    endgenerate

    logic              in_range;
    logic [VAL_W-1:0]  sel_val;
    logic [CTL_W-1:0]  sel_ctl;
    logic [TYPE_W-1:0] sel_type;
    logic [CTX_W-1:0]  cmp_id;
    logic              type_ok;

    always_comb begin
        in_range = (int'(lnk_num) < NUM_BP) && (int'(lnk_num) >= FIRST_CTX);
        sel_val  = '0;
        sel_ctl  = '0;
        if (int'(lnk_num) < NUM_BP) begin
            sel_val = val_arr[lnk_num[IDX_W-1:0]];
            sel_ctl = ctl_arr[lnk_num[IDX_W-1:0]];
        end
        sel_type = sel_ctl[TYPE_LSB +: TYPE_W];
        cmp_id   = ctx_l1;
        type_ok  = 1'b0;
        case (sel_type)
            LT_REGIME: begin
                case (lvl_e'(cur_lvl))
                    LVL_1: begin
                        cmp_id  = ctx_l1;
                        type_ok = 1'b1;
                    end
                    LVL_2: begin
                        cmp_id  = ctx_l2;
                        type_ok = host_ext;
                    end
                    LVL_0: begin
                        cmp_id  = (host_ext && gen_trap) ? ctx_l2 : ctx_l1;
                        type_ok = 1'b1;
                    end
                    default: type_ok = 1'b0;
                endcase
            end
            LT_CTX_L1: begin
                cmp_id  = ctx_l1;
                type_ok = 1'b1;
            end
            LT_CTX_L2: begin
                cmp_id  = ctx_l2;
                type_ok = 1'b1;
            end
            default: type_ok = 1'b0;
        endcase
        link_ok = in_range && sel_ctl[SLOT_EN] && type_ok &&
                  (sel_val[CTX_W-1:0] == cmp_id);
    end
endmodule

// File: rtl/dbq_qualifier.sv
module dbq_qualifier
    import dbq_pkg::*;
#(
    parameter int NUM_BP  = 16,
    parameter int NUM_CTX = 4,
    parameter int VAL_W   = 64,
    parameter int CTX_W   = 32,
    parameter int CTL_W   = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hit_in,
    input  logic                    is_wp,
    input  logic                    user_attr,
    input  logic [CWORD_W-1:0]      ctl_word,
    input  logic [1:0]              cur_lvl,
    input  logic                    secure,
    input  logic                    host_ext,
    input  logic                    gen_trap,
    input  logic [CTX_W-1:0]        ctx_l1,
    input  logic [CTX_W-1:0]        ctx_l2,
    input  logic [NUM_BP*VAL_W-1:0] lnk_val_flat,
    input  logic [NUM_BP*CTL_W-1:0] lnk_ctl_flat,
    output logic                    match_q
);
    ctl_word_t cw;
    logic sec_ok, priv_ok, link_ok, qual_d;

    assign cw = ctl_word_t'(ctl_word);

    dbq_sec_filter u_sec (
        .sec_sel (cw.sec_sel),
        .secure  (secure),
        .sec_ok  (sec_ok)
    );

    dbq_priv_filter u_priv (
        .cur_lvl   (cur_lvl),
        .is_wp     (is_wp),
        .user_attr (user_attr),
        .hi_mode   (cw.hi_mode),
        .priv_mask (cw.priv_mask),
        .priv_ok   (priv_ok)
    );

    dbq_link_match #(
        .NUM_BP (NUM_BP), .NUM_CTX (NUM_CTX), .VAL_W (VAL_W),
        .CTX_W (CTX_W), .CTL_W (CTL_W)
    ) u_link (
        .lnk_num      (cw.lnk_num),
        .cur_lvl      (cur_lvl),
        .host_ext     (host_ext),
        .gen_trap     (gen_trap),
        .ctx_l1       (ctx_l1),
        .ctx_l2       (ctx_l2),
        .lnk_val_flat (lnk_val_flat),
        .lnk_ctl_flat (lnk_ctl_flat),
        .link_ok      (link_ok)
    );

    assign qual_d = hit_in && sec_ok && priv_ok && (!cw.lnk_en || link_ok);

    always_ff @(posedge clk) begin
        if (rst) match_q <= 1'b0;
        else     match_q <= qual_d;
    end
endmodule

// File: rtl/dbq_checker.sv
module dbq_checker
    import dbq_pkg::*;
#(
    parameter int NUM_BP  = 16,
    parameter int NUM_CTX = 4,
    parameter int VAL_W   = 64,
    parameter int CTX_W   = 32,
    parameter int CTL_W   = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    hit_in,
    input logic                    is_wp,
    input logic                    user_attr,
    input logic [CWORD_W-1:0]      ctl_word,
    input logic [1:0]              cur_lvl,
    input logic                    secure,
    input logic [NUM_BP*CTL_W-1:0] lnk_ctl_flat,
    input logic                    match_q
);
    logic [1:0] eff_lvl;
    logic       slot_en;
    int         lnum;

    always_comb begin
        eff_lvl = (is_wp && user_attr) ? 2'd0 : cur_lvl;
        lnum    = int'(ctl_word[9:6]);
        slot_en = 1'b0;
        if (lnum < NUM_BP) slot_en = lnk_ctl_flat[lnum*CTL_W];
    end

    a_r1_no_hit: assert property (@(posedge clk) disable iff (rst)
        !hit_in |=> !match_q);

    a_r2_secure_blocked: assert property (@(posedge clk) disable iff (rst)
        (secure && (ctl_word[4:3] == 2'd1 || ctl_word[4:3] == 2'd3)) |=> !match_q);

    a_r2_nonsecure_blocked: assert property (@(posedge clk) disable iff (rst)
        (!secure && ctl_word[4:3] == 2'd2) |=> !match_q);

    a_r3_high_level_gate: assert property (@(posedge clk) disable iff (rst)
        (eff_lvl[1] && !ctl_word[2]) |=> !match_q);

    a_r6_link_range: assert property (@(posedge clk) disable iff (rst)
        (ctl_word[5] && lnum < NUM_BP - NUM_CTX) |=> !match_q);

    a_r7_slot_disabled: assert property (@(posedge clk) disable iff (rst)
        (ctl_word[5] && !slot_en) |=> !match_q);
endmodule

bind dbq_qualifier dbq_checker #(
    .NUM_BP (NUM_BP), .NUM_CTX (NUM_CTX), .VAL_W (VAL_W),
    .CTX_W (CTX_W), .CTL_W (CTL_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .hit_in       (hit_in),
    .is_wp        (is_wp),
    .user_attr    (user_attr),
    .ctl_word     (ctl_word),
    .cur_lvl      (cur_lvl),
    .secure       (secure),
    .lnk_ctl_flat (lnk_ctl_flat),
    .match_q      (match_q)
);

// File: tb/sim_dbq_qualifier.sv
`timescale 1ns/1ps
module sim_dbq_qualifier;
    localparam int NB = 16;
    localparam int NC = 4;

    logic clk = 1'b0;
    logic rst;
    logic hit_in, is_wp, user_attr, secure, host_ext, gen_trap;
    logic [1:0] cur_lvl;
    logic [3:0] b_lnum;
    logic b_len, b_hmc;
    logic [1:0] b_sec, b_priv;
    logic [9:0] ctl_word;
    logic [31:0] ctx_l1, ctx_l2;
    logic [63:0] bval [NB];
    logic [31:0] bctl [NB];
    logic [NB*64-1:0] lnk_val_flat;
    logic [NB*32-1:0] lnk_ctl_flat;
    logic match_q;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign ctl_word = {b_lnum, b_len, b_sec, b_hmc, b_priv};

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            lnk_val_flat[i*64 +: 64] = bval[i];
            lnk_ctl_flat[i*32 +: 32] = bctl[i];
        end
    end

    dbq_qualifier u0 (
        .clk (clk), .rst (rst), .hit_in (hit_in), .is_wp (is_wp),
        .user_attr (user_attr), .ctl_word (ctl_word), .cur_lvl (cur_lvl),
        .secure (secure), .host_ext (host_ext), .gen_trap (gen_trap),
        .ctx_l1 (ctx_l1), .ctx_l2 (ctx_l2), .lnk_val_flat (lnk_val_flat),
        .lnk_ctl_flat (lnk_ctl_flat), .match_q (match_q)
    );

    function automatic logic model();
        logic [1:0] el;
        logic ok, lk;
        logic [31:0] id;
        logic [3:0] ty;
        el = (is_wp && user_attr) ? 2'd0 : cur_lvl;
        ok = hit_in;
        if (b_sec == 2'd2 && !secure) ok = 0;
        if ((b_sec == 2'd1 || b_sec == 2'd3) && secure) ok = 0;
        if (el >= 2 && !b_hmc) ok = 0;
        if (el == 1 && !b_priv[0]) ok = 0;
        if (el == 0 && !b_priv[1]) ok = 0;
        if (b_len) begin
            lk = (int'(b_lnum) >= NB - NC) && bctl[b_lnum][0];
            ty = bctl[b_lnum][23:20];
            id = ctx_l1;
            if (ty == 4'd3) begin
                if (cur_lvl == 2'd3) lk = 0;
                else if (cur_lvl == 2'd2) begin id = ctx_l2; if (!host_ext) lk = 0; end
                else if (cur_lvl == 2'd0 && host_ext && gen_trap) id = ctx_l2;
            end else if (ty == 4'd13) id = ctx_l2;
            else if (ty != 4'd7) lk = 0;
            if (bval[b_lnum][31:0] != id) lk = 0;
            ok = ok && lk;
        end
        return ok;
    endfunction

    task automatic check(input string tag, input logic exp);
        @(negedge clk);
        total++;
        if (match_q !== exp) begin
            bad++;
            $display("FAIL %s: match_q=%0b expected=%0b", tag, match_q, exp);
        end
    endtask

    task automatic base();
        hit_in = 1; is_wp = 0; user_attr = 0; secure = 0;
        host_ext = 0; gen_trap = 0; cur_lvl = 2'd1;
        b_lnum = 4'd13; b_len = 0; b_sec = 2'd0; b_hmc = 1; b_priv = 2'b11;
        ctx_l1 = 32'h1111_AAAA; ctx_l2 = 32'h2222_BBBB;
        for (int i = 0; i < NB; i++) begin
            bval[i] = 64'hDEAD_0000_0000_0000 | 64'(i);
            bctl[i] = 32'h0;
        end
    endtask

    task automatic slot(input int n, input logic [3:0] ty, input logic en,
                        input logic [63:0] v);
        bctl[n] = {8'h0, ty, 19'h0, en};
        bval[n] = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run did not finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        base();
        rst = 1;
        @(negedge clk);
        check("R1 reset holds low", 1'b0);
        rst = 0;
        check("R1 plain hit accepted", 1'b1);
        hit_in = 0; check("R1 no hit", 1'b0);

        base(); b_sec = 2'd2; check("R2 sel2 nonsecure", 1'b0);
        secure = 1; check("R2 sel2 secure", 1'b1);
        b_sec = 2'd1; check("R2 sel1 secure", 1'b0);
        b_sec = 2'd3; check("R2 sel3 secure", 1'b0);
        secure = 0; check("R2 sel3 nonsecure", 1'b1);
        b_sec = 2'd0; secure = 1; check("R2 sel0 secure", 1'b1);

        base(); cur_lvl = 2'd2; b_hmc = 0; check("R3 level2 no enable", 1'b0);
        cur_lvl = 2'd3; b_hmc = 1; check("R3 level3 enabled", 1'b1);

        base(); b_priv = 2'b10; check("R4 level1 mask bit0 clear", 1'b0);
        cur_lvl = 2'd0; check("R4 level0 mask bit1 set", 1'b1);
        b_priv = 2'b01; check("R4 level0 mask bit1 clear", 1'b0);

        base(); cur_lvl = 2'd2; b_hmc = 0; b_priv = 2'b10;
        is_wp = 1; user_attr = 1; check("R5 wp user as level0", 1'b1);
        is_wp = 0; check("R5 bp ignores user attr", 1'b0);

        base(); b_len = 1;
        slot(13, 4'd7, 1, {32'h0, ctx_l1}); check("R9 type7 level1 id", 1'b1);
        slot(11, 4'd7, 1, {32'h0, ctx_l1}); b_lnum = 11; check("R6 slot below range", 1'b0);
        slot(12, 4'd7, 1, {32'h0, ctx_l1}); b_lnum = 12; check("R6 lowest ctx slot", 1'b1);
        slot(15, 4'd7, 1, {32'h0, ctx_l1}); b_lnum = 15; check("R6 top slot", 1'b1);
        slot(15, 4'd7, 0, {32'h0, ctx_l1}); check("R7 slot disabled", 1'b0);
        slot(15, 4'd13, 1, {32'h0, ctx_l2}); check("R9 type13 level2 id", 1'b1);
        slot(15, 4'd13, 1, {32'h0, ctx_l1}); check("R9 type13 wrong id", 1'b0);
        slot(15, 4'd9, 1, {32'h0, ctx_l1}); check("R9 type9 rejected", 1'b0);

        slot(15, 4'd3, 1, {32'h0, ctx_l1}); check("R8 regime level1", 1'b1);
        slot(15, 4'd3, 1, {32'h0, ctx_l2}); cur_lvl = 2'd2;
        check("R8 regime level2 no host", 1'b0);
        host_ext = 1; check("R8 regime level2 host", 1'b1);
        cur_lvl = 2'd0; gen_trap = 1; check("R8 regime level0 host+trap", 1'b1);
        gen_trap = 0; check("R8 regime level0 host only", 1'b0);
        slot(15, 4'd3, 1, {32'h0, ctx_l1}); check("R8 regime level0 uses l1", 1'b1);
        cur_lvl = 2'd3; check("R8 regime level3 fails", 1'b0);

        base(); b_len = 1; b_lnum = 14;
        slot(14, 4'd7, 1, {32'hFFFF_0123, ctx_l1}); check("R10 upper bits ignored", 1'b1);
        slot(14, 4'd7, 1, {ctx_l1, 32'h0}); check("R10 low bits differ", 1'b0);
        b_len = 0; b_lnum = 3; check("R11 link off ignores bank", 1'b1);

        for (int k = 0; k < 3000; k++) begin
            hit_in = ($urandom % 8) != 0; is_wp = $urandom; user_attr = $urandom;
            secure = $urandom; host_ext = $urandom; gen_trap = $urandom;
            cur_lvl = 2'($urandom); b_lnum = 4'($urandom); b_len = $urandom;
            b_sec = ($urandom % 2) ? 2'd0 : 2'($urandom);
            b_hmc = ($urandom % 4) != 0; b_priv = ($urandom % 2) ? 2'b11 : 2'($urandom);
            ctx_l1 = ($urandom % 2) ? 32'h1111_AAAA : $urandom;
            ctx_l2 = 32'h2222_BBBB;
            for (int i = 0; i < NB; i++) begin
                int pick;
                logic [3:0] ty;
                pick = $urandom % 4;
                ty = (pick == 0) ? 4'd3 : (pick == 1) ? 4'd7 :
                     (pick == 2) ? 4'd13 : 4'($urandom);
                slot(i, ty, ($urandom % 5) != 0,
                     {$urandom, (($urandom % 2) ? ctx_l1 : ctx_l2)});
            end
            check("R1 random vs model", model());
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule